// File: doc/BRIEF.md
# Circular Transmit FIFO Index Manager

This block tracks the bookkeeping of a circular transmit FIFO whose elements live in a shared message RAM. It holds a read (head) index, a write (tail) index and an occupancy count, and from them presents the number of free elements, a full flag and the RAM word address where software should place the next message. The message contents, the transmission itself and the choice between FIFO and priority-queue operation are handled elsewhere. This block only reacts to the events that move the indices.

Software adds one or several messages in a single write by setting a contiguous run of bits in an add-request vector that starts at the tail index. The block counts the set bits and advances the tail by that many, wrapping. The transmitter pulses a done input after each message leaves, and the head advances by one. A cancel aimed at the head element makes the head skip forward to the next occupied element that still has a pending request. A cancel aimed at any other element has no effect on the indices. Each element takes four 32-bit words, so the element address is the RAM start address plus four times the tail index.

An occupancy count is kept next to the two indices, so an empty FIFO and a full FIFO remain distinct when the indices are equal. An add that asks for more elements than are free is refused as a whole and reported on an error pulse.

Top module: `txq_fifo_index`

## Requirements
- R1: After reset the head and tail indices are 0, the free level equals DEPTH, the full flag is 0 and the error pulse is 0.
- R2: With the queue-mode input at 0, an add-request vector with n set bits (counted regardless of position), where 0 < n <= free level, advances the tail index by n modulo DEPTH and lowers the free level by n. These changes are visible after the next rising clock edge.
- R3: The full flag is 1 exactly when the free level is 0. An empty FIFO with equal indices shows a free level of DEPTH and full at 0.
- R4: A done pulse while the FIFO holds at least one element advances the head index by 1 modulo DEPTH and raises the free level by 1. A done pulse on an empty FIFO is ignored.
- R5: A cancel bit set at the head index while the FIFO is not empty moves the head forward by the smallest k in 1..occupancy-1 for which the buffer at (head+k) mod DEPTH has its pending bit set and its cancel bit clear. If there is no such k, the head moves to the tail and the FIFO becomes empty. The free level rises by the distance moved. A done pulse in the same cycle is ignored.
- R6: Cancel bits that do not hit the head index, or any cancel on an empty FIFO, leave the head index and the free level unchanged.
- R7: An add request with n greater than the current free level is ignored entirely, and the error output is 1 for exactly the following cycle.
- R8: While the queue-mode input is 1, add, done and cancel inputs are all ignored: indices and free level hold and no error is raised.
- R9: The element address output equals base address + 4 x tail index, combinationally in the same cycle.
- R10: An add and a done pulse in the same cycle are both applied. The add is admitted or refused against the free level before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| queue_mode | input | 1 | 0 = FIFO operation; 1 = queue operation, block frozen |
| base_addr | input | ADDR_W | RAM word address of element 0 |
| add_req | input | DEPTH | Add-request bits, one per buffer; count of set bits is n |
| tx_done | input | 1 | One-cycle pulse per completed transmission |
| cancel_req | input | DEPTH | Cancellation bits, one per buffer |
| pending | input | DEPTH | Per-buffer pending-request status |
| get_idx | output | IDX_W | Head index |
| put_idx | output | IDX_W | Tail index |
| free_lvl | output | IDX_W+1 | Number of free elements |
| full | output | 1 | FIFO full |
| elem_addr | output | ADDR_W | RAM word address of the next free element |
| add_err | output | 1 | One-cycle pulse after a refused add |

## Verification
The bench uses an 8-element instance. It fills the FIFO with every run length from every starting position, so that any wrap slip shows up as a wrong tail, a wrong address or a missed full flag. It drains each run to the empty state and then sends one more done pulse, which catches an underflow that would move the head past the tail. Every 8-bit pending pattern is tried for a head cancel at occupancies 1, 5 and 8. A design that scanned past the occupied window, skipped to the wrong buffer, or forgot to treat an all-clear pattern as emptying the FIFO gives the wrong head. Over-sized adds, adds and done pulses in the same cycle at the full boundary, cancels of non-head buffers, and queue mode are each checked to change nothing they must not touch.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {
    HEAD_HOLD   = 2'd0,
    HEAD_STEP   = 2'd1,
    HEAD_SKIP   = 2'd2
  } head_move_e;

  // modular add for operands with a < m and b <= m
  function automatic int unsigned wrap_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned m);
    int unsigned s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction

endpackage

// File: rtl/txq_popcount.sv
module txq_popcount #(
  parameter int W   = 32,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     bits,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CNT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/txq_head_skip.sv
module txq_head_skip
  import txq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic [IDX_W-1:0] head,
  input  logic [CNT_W-1:0] occupancy,
  input  logic [DEPTH-1:0] pending,
  input  logic [DEPTH-1:0] cancel,
  output logic [CNT_W-1:0] distance
);
  // live[k]: buffer k places after the head still wants to go out
  logic [DEPTH-1:0] live;

  for (genvar k = 0; k < DEPTH; k++) begin : g_rot
    logic [IDX_W-1:0] slot;
    assign slot    = IDX_W'(wrap_add(32'(head), 32'(k), 32'(DEPTH)));
    assign live[k] = pending[slot] & ~cancel[slot];
  end

  // nearest live buffer inside the occupied window, else empty out
  always_comb begin
    distance = occupancy;
    for (int k = DEPTH - 1; k >= 1; k--) begin
      if (live[k] && (CNT_W'(k) < occupancy)) distance = CNT_W'(k);
    end
  end
endmodule

// File: rtl/txq_fifo_index.sv
module txq_fifo_index
  import txq_pkg::*;
#(
  parameter int DEPTH          = 32,
  parameter int ADDR_W         = 14,
  parameter int WORDS_PER_ELEM = 4,
  localparam int IDX_W         = $clog2(DEPTH),
  localparam int CNT_W         = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queue_mode,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DEPTH-1:0]  add_req,
  input  logic              tx_done,
  input  logic [DEPTH-1:0]  cancel_req,
  input  logic [DEPTH-1:0]  pending,
  output logic [IDX_W-1:0]  get_idx,
  output logic [IDX_W-1:0]  put_idx,
  output logic [CNT_W-1:0]  free_lvl,
  output logic              full,
  output logic [ADDR_W-1:0] elem_addr,
  output logic              add_err
);
  localparam logic [CNT_W-1:0]  CAP    = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORDS_PER_ELEM);

  logic [IDX_W-1:0] get_q, put_q;
  logic [CNT_W-1:0] occ_q;
  logic             err_q;

  logic [CNT_W-1:0] add_n;
  logic [CNT_W-1:0] skip_dist;
  logic [CNT_W-1:0] head_adv;
  logic [CNT_W-1:0] tail_adv;
  logic             active, nonempty, head_cancel, add_ok, add_bad;
  head_move_e       move;

  txq_popcount #(.W(DEPTH), .CNT_W(CNT_W)) u_count (
    .bits  (add_req),
    .count (add_n)
  );

  txq_head_skip #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_skip (
    .head      (get_q),
    .occupancy (occ_q),
    .pending   (pending),
    .cancel    (cancel_req),
    .distance  (skip_dist)
  );

  assign active      = !queue_mode;
  assign nonempty    = (occ_q != '0);
  assign head_cancel = active && nonempty && cancel_req[get_q];

  // head movement: a head cancel outranks a completed transmission
  always_comb begin
    move = HEAD_HOLD;
    if (head_cancel)                     move = HEAD_SKIP;
    else if (active && tx_done && nonempty) move = HEAD_STEP;
  end

  always_comb begin
    unique case (move)
      HEAD_STEP: head_adv = CNT_W'(1);
      HEAD_SKIP: head_adv = skip_dist;
      default:   head_adv = '0;
    endcase
  end

  // admission is judged against the free level held before this edge
  assign add_ok   = active && (add_n != '0) && (add_n <= free_lvl);
  assign add_bad  = active && (add_n > free_lvl);
  assign tail_adv = add_ok ? add_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      get_q <= '0;
      put_q <= '0;
      occ_q <= '0;
      err_q <= 1'b0;
    end else begin
      get_q <= IDX_W'(wrap_add(32'(get_q), 32'(head_adv), 32'(DEPTH)));
      put_q <= IDX_W'(wrap_add(32'(put_q), 32'(tail_adv), 32'(DEPTH)));
      occ_q <= occ_q - head_adv + tail_adv;
      err_q <= add_bad;
    end
  end

  assign get_idx   = get_q;
  assign put_idx   = put_q;
  assign free_lvl  = CAP - occ_q;
  assign full      = (occ_q == CAP);
  assign add_err   = err_q;
  assign elem_addr = base_addr + ADDR_W'(put_q) * STRIDE;

  // ---------------- assertions ----------------
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CAP);

  a_r4_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tx_done && nonempty && !head_cancel && add_n == '0)
    |=> (free_lvl == $past(free_lvl) + CNT_W'(1)) && (put_idx == $past(put_idx)));

  a_r6_other_cancel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tx_done && !cancel_req[get_q] && add_n == '0)
    |=> $stable(get_idx) && $stable(free_lvl));

  a_r7_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (active && add_n > free_lvl) |=> add_err && $stable(put_idx));

  a_r8_queue_hold: assert property (@(posedge clk) disable iff (!rst_n)
    queue_mode |=> $stable(get_idx) && $stable(put_idx) && $stable(free_lvl) && !add_err);

  a_r3_full_no_put: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !head_cancel) |=> $stable(put_idx));

  a_r5_skip_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (head_cancel && add_n == '0) |=> free_lvl > $past(free_lvl));
endmodule

// File: tb/txq_fifo_index_test.sv
`timescale 1ns/1ps
module txq_fifo_index_test;
  localparam int D  = 8;
  localparam int AW = 14;
  localparam int IW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          queue_mode = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [D-1:0]  add_req = '0;
  logic          tx_done = 1'b0;
  logic [D-1:0]  cancel_req = '0;
  logic [D-1:0]  pending = '0;
  logic [IW-1:0] get_idx, put_idx;
  logic [CW-1:0] free_lvl;
  logic          full, add_err;
  logic [AW-1:0] elem_addr;

  int total = 0;
  int bad = 0;
  int mg, mp, mocc;
  logic merr;

  always #10 clk = ~clk;

  txq_fifo_index #(.DEPTH(D), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode), .base_addr(base_addr),
    .add_req(add_req), .tx_done(tx_done), .cancel_req(cancel_req),
    .pending(pending), .get_idx(get_idx), .put_idx(put_idx),
    .free_lvl(free_lvl), .full(full), .elem_addr(elem_addr), .add_err(add_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "get_idx", int'(get_idx), mg);
    chk(tag, "put_idx", int'(put_idx), mp);
    chk(tag, "free_lvl", int'(free_lvl), D - mocc);
    chk({tag, " R3"}, "full", int'(full), (mocc == D) ? 1 : 0);
    chk({tag, " R9"}, "elem_addr", int'(elem_addr), (int'(base_addr) + 4 * mp) % (1 << AW));
    chk(tag, "add_err", int'(add_err), int'(merr));
  endtask

  function automatic logic [D-1:0] run_bits(input int start, input int n);
    logic [D-1:0] v = '0;
    for (int i = 0; i < n; i++) v[(start + i) % D] = 1'b1;
    return v;
  endfunction

  // one cycle of stimulus; expected state derived from the requirements
  task automatic apply(input logic [D-1:0] a, input logic d, input logic [D-1:0] c,
                       input logic [D-1:0] pd, input logic q, input string tag);
    int n, adv;
    n = $countones(a);
    adv = 0;
    merr = 1'b0;
    if (!q) begin
      if (mocc > 0 && c[mg]) begin
        adv = mocc;
        for (int k = mocc - 1; k >= 1; k--)
          if (pd[(mg + k) % D] && !c[(mg + k) % D]) adv = k;
      end else if (d && mocc > 0) begin
        adv = 1;
      end
      merr = (n > D - mocc);
      mg = (mg + adv) % D;
      if (n > 0 && n <= D - mocc) begin
        mp = (mp + n) % D;
        mocc = mocc + n;
      end
      mocc = mocc - adv;
    end
    add_req = a; tx_done = d; cancel_req = c; pending = pd; queue_mode = q;
    @(posedge clk);
    @(negedge clk);
    add_req = '0; tx_done = 1'b0; cancel_req = '0; pending = '0; queue_mode = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mg = 0; mp = 0; mocc = 0; merr = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    base_addr = 14'h0100;
    do_reset();
    check_all("R1 reset");

    // R2/R4/R9: every run length from every start position, then drain
    for (int s = 0; s < D; s++) begin
      for (int n = 1; n <= D; n++) begin
        base_addr = AW'(s * 37 + n);
        apply(run_bits(mp, n), 1'b0, '0, '0, 1'b0, "R2 add run");
        for (int t = 0; t < n; t++) apply('0, 1'b1, '0, '0, 1'b0, "R4 drain");
        apply('0, 1'b1, '0, '0, 1'b0, "R4 done on empty");
      end
      apply('0, 1'b1, '0, '0, 1'b0, "R4 align");
      apply(run_bits(mp, 1), 1'b0, '0, '0, 1'b0, "R2 shift");
      apply('0, 1'b1, '0, '0, 1'b0, "R4 shift drain");
    end

    // R7: oversize add refused, error for one cycle only
    do_reset();
    apply(run_bits(0, 6), 1'b0, '0, '0, 1'b0, "R2 fill6");
    apply(run_bits(6, 3), 1'b0, '0, '0, 1'b0, "R7 oversize");
    apply('0, 1'b0, '0, '0, 1'b0, "R7 error clears");
    apply(run_bits(6, 2), 1'b0, '0, '0, 1'b0, "R3 fill to full");

    // R6: non-head cancels on a full FIFO
    for (int b = 1; b < D; b++)
      apply('0, 1'b0, run_bits(b, 1), 8'hFF, 1'b0, "R6 other cancel");

    // R10: add with done at full is refused; below full both apply
    apply(run_bits(0, 1), 1'b1, '0, '0, 1'b0, "R10 add+done at full");
    apply(run_bits(0, 1), 1'b1, '0, '0, 1'b0, "R10 add+done below full");
    apply('0, 1'b1, '0, '0, 1'b0, "R4 step");
    apply(run_bits(mp, 2), 1'b1, '0, '0, 1'b0, "R10 add2+done");

    // R8: queue mode freezes everything
    apply(run_bits(mp, 1), 1'b1, run_bits(mg, 1), '0, 1'b1, "R8 queue frozen");
    apply(8'hFF, 1'b0, '0, '0, 1'b1, "R8 queue no err");

    // R5: head cancel against every pending pattern at three occupancies
    for (int o = 0; o < 3; o++) begin
      for (int p = 0; p < 256; p++) begin
        do_reset();
        apply(run_bits(0, 8), 1'b0, '0, '0, 1'b0, "R5 prep fill");
        apply('0, 1'b1, '0, '0, 1'b0, "R5 prep drain");
        apply('0, 1'b1, '0, '0, 1'b0, "R5 prep drain");
        apply('0, 1'b1, '0, '0, 1'b0, "R5 prep drain");
        if (o == 2) apply(run_bits(0, 3), 1'b0, '0, '0, 1'b0, "R5 prep refill");
        if (o == 0)
          for (int t = 0; t < 4; t++) apply('0, 1'b1, '0, '0, 1'b0, "R5 prep drain");
        apply('0, 1'b0, run_bits(mg, 1), D'(p), 1'b0, "R5 head cancel");
      end
    end

    // R5: cancel of a later buffer masks its pending bit; done ignored
    do_reset();
    apply(run_bits(0, 6), 1'b0, '0, '0, 1'b0, "R5 prep");
    apply('0, 1'b1, 8'b0000_0011, 8'b0011_1110, 1'b0, "R5 masked skip");
    apply('0, 1'b0, run_bits(mg, 1), '0, 1'b0, "R5 cancel empties");
    apply('0, 1'b0, run_bits(mg, 1), 8'hFF, 1'b0, "R6 cancel on empty");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule